// File: doc/BRIEF.md
# Debug Host Mailbox Port

This block sits on a development board between a host bus and a target processor and carries debug traffic between them. The host sees six byte-addressed ports: a status word, a command/result byte, a 16-bit data port, a control port that takes acknowledge codes, a mode port holding the command-pending flag, and a reset port holding the boot mode. The target sees a small byte register set (status, byte window, acknowledge) and a word interface onto two FIFOs.

A command byte is armed by the host through the pending bit of the mode port. The target releases it by writing an acknowledge code. A result byte goes the other way. Its status flag is dropped only by a distinct acknowledge code on the host control port, and a second result written before that acknowledge raises a sticky overrun flag. Bulk data moves as 16-bit words through one FIFO per direction. A trigger code on the control port, followed directly by a fixed value on the mode port, fires a target reset pulse of fixed length that carries the latched boot mode.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the host status word reads 0x000C (bit 3 command accept, bit 2 write ready), `tgt_rst_o` is low and `boot_mode_o` is 0.
- R2: A host write to port 1 followed by a mode-port (port 5) write with bit 4 set raises the pending flag. Host status bit 3 and mode read bit 4 then show it, target status (target address 0) bit 4 is set, and target address 1 reads the byte. A mode write with bit 4 clear arms nothing. A target write of 0x20 to target address 2 clears the flag.
- R3: A host control (port 4) write of 0x20 clears host status bit 4. Other control codes leave it set.
- R4: A target byte write to target address 1 sets host status bit 4 on the next clock and clears target status bit 3. Host port 1 then reads the byte.
- R5: A second target byte write before the host acknowledge replaces the byte and sets host status bit 5. That bit stays set through acknowledges and is cleared only by control code 0x01.
- R6: Host writes to port 2 reach `tgt_word_o` in order. Host status bit 2 drops when FIFO_DEPTH words are queued, and writes while full are discarded.
- R7: Words pushed by the target are read in order from host port 2. Status bit 0 is set while any word is queued. Bit 1 is set while at least BULK_LVL words are queued.
- R8: Control code 0x71 followed by mode-port value 0x01 drives `tgt_rst_o` high for exactly RST_LEN cycles. For the whole pulse `boot_mode_o` equals bits 1:0 of the last reset-port (port 6) write, and it is 0 outside the pulse.
- R9: A mode write of 0x01 that does not directly follow code 0x71 triggers no reset. Any other control or mode write in between cancels the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_sel_i | input | 1 | Host access strobe, one cycle per access |
| hst_wr_i | input | 1 | Host access is a write |
| hst_addr_i | input | 3 | Host port offset |
| hst_wdata_i | input | 16 | Host write data |
| hst_rdata_o | output | 16 | Host read data for the addressed port |
| tgt_sel_i | input | 1 | Target register access strobe |
| tgt_wr_i | input | 1 | Target access is a write |
| tgt_addr_i | input | 2 | Target register index |
| tgt_wdata_i | input | 8 | Target write byte |
| tgt_rdata_o | output | 8 | Target read byte |
| tgt_pop_i | input | 1 | Target takes the head host-to-target word |
| tgt_word_o | output | 16 | Head host-to-target word |
| tgt_word_vld_o | output | 1 | Host-to-target FIFO not empty |
| tgt_push_i | input | 1 | Target pushes a word toward the host |
| tgt_push_word_i | input | 16 | Word pushed by the target |
| tgt_full_o | output | 1 | Target-to-host FIFO full |
| tgt_rst_o | output | 1 | Target reset pulse |
| boot_mode_o | output | 2 | Boot mode during the reset pulse |

## Verification
The bench builds the block with FIFO_DEPTH 8 and BULK_LVL 4 and keeps RST_LEN at 16. At these sizes the full-FIFO drop, the bulk threshold crossing and the drain back to empty each take only a few accesses. The reset pulse is counted cycle by cycle with the boot mode checked on every cycle, for two different boot modes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [2:0] HA_STATUS = 3'd0;
  localparam logic [2:0] HA_BYTE   = 3'd1;
  localparam logic [2:0] HA_DATA   = 3'd2;
  localparam logic [2:0] HA_CTL    = 3'd4;
  localparam logic [2:0] HA_MODE   = 3'd5;
  localparam logic [2:0] HA_RST    = 3'd6;

  localparam logic [1:0] TA_STATUS = 2'd0;
  localparam logic [1:0] TA_BYTE   = 2'd1;
  localparam logic [1:0] TA_ACK    = 2'd2;

  localparam logic [7:0] CODE_ACK  = 8'h20;
  localparam logic [7:0] CODE_FIN  = 8'h01;
  localparam logic [7:0] CODE_ARM  = 8'h71;
  localparam logic [7:0] MODE_FIRE = 8'h01;
  localparam int         PEND_BIT  = 4;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] level_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign level_o = cnt_q;
  assign dout_o  = mem_q[rp_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       arm_i,
  input  logic       tgt_ack_i,
  input  logic       res_wr_i,
  input  logic [7:0] res_byte_i,
  input  logic       hst_ack_i,
  input  logic       hst_fin_i,
  output logic [7:0] cmd_byte_o,
  output logic       cmd_pend_o,
  output logic [7:0] res_byte_o,
  output logic       res_vld_o,
  output logic       ovr_o
);
  logic [7:0] cmd_q, res_q;
  logic       pend_q, vld_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      res_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      // command byte locked while pending
      if (cmd_wr_i && !pend_q) cmd_q <= cmd_byte_i;
      if (arm_i)          pend_q <= 1'b1;
      else if (tgt_ack_i) pend_q <= 1'b0;
      if (res_wr_i) begin
        res_q <= res_byte_i;
        vld_q <= 1'b1;
      end else if (hst_ack_i) begin
        vld_q <= 1'b0;
      end
      if (res_wr_i && vld_q && !hst_ack_i) ovr_q <= 1'b1;
      else if (hst_fin_i)                   ovr_q <= 1'b0;
    end
  end

  assign cmd_byte_o = cmd_q;
  assign cmd_pend_o = pend_q;
  assign res_byte_o = res_q;
  assign res_vld_o  = vld_q;
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/mbx_reset_gen.sv
module mbx_reset_gen #(
  parameter int RST_LEN = 16,
  parameter int MW      = 2,
  localparam int NW     = $clog2(RST_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [7:0]    ctl_data_i,
  input  logic          mode_wr_i,
  input  logic [7:0]    mode_data_i,
  input  logic          sel_wr_i,
  input  logic [MW-1:0] sel_data_i,
  output logic          tgt_rst_o,
  output logic [MW-1:0] boot_mode_o
);
  logic          armed_q;
  logic [MW-1:0] sel_q, snap_q;
  logic [NW-1:0] cnt_q;
  logic          busy, fire;

  assign busy = (cnt_q != '0);
  assign fire = mode_wr_i && armed_q && (mode_data_i == mbx_pkg::MODE_FIRE) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
      snap_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (ctl_wr_i)       armed_q <= (ctl_data_i == mbx_pkg::CODE_ARM);
      else if (mode_wr_i) armed_q <= 1'b0;
      if (sel_wr_i) sel_q <= sel_data_i;
      if (fire) begin
        cnt_q  <= NW'(RST_LEN);
        snap_q <= sel_q;
      end else if (busy) begin
        cnt_q <= cnt_q - NW'(1);
      end
    end
  end

  assign tgt_rst_o   = busy;
  assign boot_mode_o = busy ? snap_q : '0;
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int FIFO_DEPTH = 64,
  parameter int BULK_LVL   = 32,
  parameter int RST_LEN    = 16,
  localparam int DW        = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hst_sel_i,
  input  logic          hst_wr_i,
  input  logic [2:0]    hst_addr_i,
  input  logic [DW-1:0] hst_wdata_i,
  output logic [DW-1:0] hst_rdata_o,
  input  logic          tgt_sel_i,
  input  logic          tgt_wr_i,
  input  logic [1:0]    tgt_addr_i,
  input  logic [7:0]    tgt_wdata_i,
  output logic [7:0]    tgt_rdata_o,
  input  logic          tgt_pop_i,
  output logic [DW-1:0] tgt_word_o,
  output logic          tgt_word_vld_o,
  input  logic          tgt_push_i,
  input  logic [DW-1:0] tgt_push_word_i,
  output logic          tgt_full_o,
  output logic          tgt_rst_o,
  output logic [1:0]    boot_mode_o
);
  import mbx_pkg::*;

  logic hw, hr, tw;
  logic h_byte_wr, h_data_wr, h_data_rd, h_ctl_wr, h_mode_wr, h_rst_wr;
  logic t_byte_wr, t_ack_wr;
  logic h_ack, h_fin, arm;

  logic [7:0]       cmd_byte, res_byte;
  logic             cmd_pend, res_vld, ovr;
  logic             h2t_empty, h2t_full, t2h_empty, t2h_full;
  logic [LVL_W-1:0] h2t_lvl, t2h_lvl;
  logic [DW-1:0]    t2h_head;
  logic [DW-1:0]    hst_status;

  assign hw = hst_sel_i & hst_wr_i;
  assign hr = hst_sel_i & ~hst_wr_i;
  assign tw = tgt_sel_i & tgt_wr_i;

  assign h_byte_wr = hw && hst_addr_i == HA_BYTE;
  assign h_data_wr = hw && hst_addr_i == HA_DATA;
  assign h_data_rd = hr && hst_addr_i == HA_DATA;
  assign h_ctl_wr  = hw && hst_addr_i == HA_CTL;
  assign h_mode_wr = hw && hst_addr_i == HA_MODE;
  assign h_rst_wr  = hw && hst_addr_i == HA_RST;
  assign t_byte_wr = tw && tgt_addr_i == TA_BYTE;
  assign t_ack_wr  = tw && tgt_addr_i == TA_ACK && tgt_wdata_i == CODE_ACK;

  assign h_ack = h_ctl_wr && hst_wdata_i[7:0] == CODE_ACK;
  assign h_fin = h_ctl_wr && hst_wdata_i[7:0] == CODE_FIN;
  assign arm   = h_mode_wr && hst_wdata_i[PEND_BIT];

  mbx_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (h_byte_wr),
    .cmd_byte_i (hst_wdata_i[7:0]),
    .arm_i      (arm),
    .tgt_ack_i  (t_ack_wr),
    .res_wr_i   (t_byte_wr),
    .res_byte_i (tgt_wdata_i),
    .hst_ack_i  (h_ack),
    .hst_fin_i  (h_fin),
    .cmd_byte_o (cmd_byte),
    .cmd_pend_o (cmd_pend),
    .res_byte_o (res_byte),
    .res_vld_o  (res_vld),
    .ovr_o      (ovr)
  );

  mbx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_h2t (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (h_data_wr),
    .din_i   (hst_wdata_i),
    .pop_i   (tgt_pop_i),
    .dout_o  (tgt_word_o),
    .empty_o (h2t_empty),
    .full_o  (h2t_full),
    .level_o (h2t_lvl)
  );

  mbx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_t2h (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tgt_push_i),
    .din_i   (tgt_push_word_i),
    .pop_i   (h_data_rd),
    .dout_o  (t2h_head),
    .empty_o (t2h_empty),
    .full_o  (t2h_full),
    .level_o (t2h_lvl)
  );

  mbx_reset_gen #(.RST_LEN(RST_LEN), .MW(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (h_ctl_wr),
    .ctl_data_i  (hst_wdata_i[7:0]),
    .mode_wr_i   (h_mode_wr),
    .mode_data_i (hst_wdata_i[7:0]),
    .sel_wr_i    (h_rst_wr),
    .sel_data_i  (hst_wdata_i[1:0]),
    .tgt_rst_o   (tgt_rst_o),
    .boot_mode_o (boot_mode_o)
  );

  assign tgt_word_vld_o = ~h2t_empty;
  assign tgt_full_o     = t2h_full;

  assign hst_status = {10'b0, ovr, res_vld, ~cmd_pend, ~h2t_full,
                       (t2h_lvl >= LVL_W'(BULK_LVL)), ~t2h_empty};

  always_comb begin
    unique case (hst_addr_i)
      HA_STATUS: hst_rdata_o = hst_status;
      HA_BYTE:   hst_rdata_o = {8'b0, res_byte};
      HA_DATA:   hst_rdata_o = t2h_empty ? '0 : t2h_head;
      HA_MODE:   hst_rdata_o = DW'(cmd_pend) << PEND_BIT;
      default:   hst_rdata_o = '0;
    endcase
  end

  always_comb begin
    unique case (tgt_addr_i)
      TA_STATUS: tgt_rdata_o = {3'b0, cmd_pend, ~res_vld, 3'b0};
      TA_BYTE:   tgt_rdata_o = cmd_byte;
      default:   tgt_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hst_sel_i,
  input logic          hst_wr_i,
  input logic [2:0]    hst_addr_i,
  input logic [7:0]    hst_wdata_i,
  input logic          tgt_sel_i,
  input logic          tgt_wr_i,
  input logic [1:0]    tgt_addr_i,
  input logic [7:0]    tgt_wdata_i,
  input logic          cmd_pend,
  input logic          res_vld,
  input logic          ovr,
  input logic [LW-1:0] h2t_lvl,
  input logic          tgt_rst_o,
  input logic [1:0]    boot_mode_o
);
  logic c_hack, c_fin, c_arm, c_tres, c_tack;
  assign c_hack = hst_sel_i && hst_wr_i && hst_addr_i == 3'd4 && hst_wdata_i == 8'h20;
  assign c_fin  = hst_sel_i && hst_wr_i && hst_addr_i == 3'd4 && hst_wdata_i == 8'h01;
  assign c_arm  = hst_sel_i && hst_wr_i && hst_addr_i == 3'd5 && hst_wdata_i[4];
  assign c_tres = tgt_sel_i && tgt_wr_i && tgt_addr_i == 2'd1;
  assign c_tack = tgt_sel_i && tgt_wr_i && tgt_addr_i == 2'd2 && tgt_wdata_i == 8'h20;

  assert_cmd_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_tack && !c_arm |=> !cmd_pend);
  assert_cmd_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_arm |=> cmd_pend);
  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_hack && !c_tres |=> !res_vld);
  assert_result_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_tres |=> res_vld);
  assert_overrun_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_tres && res_vld && !c_hack |=> ovr);
  assert_overrun_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr && !c_fin |=> ovr);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h2t_lvl <= LW'(DEPTH));
  assert_boot_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o && $past(tgt_rst_o) |-> $stable(boot_mode_o));
  assert_boot_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_rst_o |-> boot_mode_o == 2'd0);
endmodule

bind dbg_mailbox mbx_checker #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_sel_i   (hst_sel_i),
  .hst_wr_i    (hst_wr_i),
  .hst_addr_i  (hst_addr_i),
  .hst_wdata_i (hst_wdata_i[7:0]),
  .tgt_sel_i   (tgt_sel_i),
  .tgt_wr_i    (tgt_wr_i),
  .tgt_addr_i  (tgt_addr_i),
  .tgt_wdata_i (tgt_wdata_i),
  .cmd_pend    (cmd_pend),
  .res_vld     (res_vld),
  .ovr         (ovr),
  .h2t_lvl     (h2t_lvl),
  .tgt_rst_o   (tgt_rst_o),
  .boot_mode_o (boot_mode_o)
);

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;
  localparam int DEPTH = 8;
  localparam int BULK  = 4;
  localparam int RLEN  = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hst_sel_i = 0, hst_wr_i = 0;
  logic [2:0]  hst_addr_i = 0;
  logic [15:0] hst_wdata_i = 0;
  logic [15:0] hst_rdata_o;
  logic        tgt_sel_i = 0, tgt_wr_i = 0;
  logic [1:0]  tgt_addr_i = 0;
  logic [7:0]  tgt_wdata_i = 0;
  logic [7:0]  tgt_rdata_o;
  logic        tgt_pop_i = 0;
  logic [15:0] tgt_word_o;
  logic        tgt_word_vld_o;
  logic        tgt_push_i = 0;
  logic [15:0] tgt_push_word_i = 0;
  logic        tgt_full_o;
  logic        tgt_rst_o;
  logic [1:0]  boot_mode_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] exp_q [$];

  always #5 clk_i = ~clk_i;

  dbg_mailbox #(.FIFO_DEPTH(DEPTH), .BULK_LVL(BULK), .RST_LEN(RLEN)) i_dbg_mailbox (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i);
    hst_sel_i = 1; hst_wr_i = 1; hst_addr_i = a; hst_wdata_i = d;
    @(negedge clk_i);
    hst_sel_i = 0; hst_wr_i = 0;
  endtask

  task automatic hrd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    hst_sel_i = 1; hst_wr_i = 0; hst_addr_i = a;
    #1 d = hst_rdata_o;
    @(negedge clk_i);
    hst_sel_i = 0;
  endtask

  task automatic twr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    tgt_sel_i = 1; tgt_wr_i = 1; tgt_addr_i = a; tgt_wdata_i = d;
    @(negedge clk_i);
    tgt_sel_i = 0; tgt_wr_i = 0;
  endtask

  task automatic trd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    tgt_addr_i = a;
    #1 d = tgt_rdata_o;
  endtask

  // driver: host words into FIFO, expectation into scoreboard
  task automatic drive_word(logic [15:0] w, bit accepted);
    hwr(3'd2, w);
    if (accepted) exp_q.push_back(w);
  endtask

  // monitor: pop target words and compare against scoreboard
  task automatic monitor_drain(string tag);
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      @(negedge clk_i);
      chk({tag, " valid"}, tgt_word_vld_o, 1);
      chk({tag, " word"}, tgt_word_o, e);
      tgt_pop_i = 1;
      @(negedge clk_i);
      tgt_pop_i = 0;
    end
  endtask

  task automatic tpush(logic [15:0] w);
    @(negedge clk_i);
    tgt_push_i = 1; tgt_push_word_i = w;
    exp_q.push_back(w);
    @(negedge clk_i);
    tgt_push_i = 0;
  endtask

  task automatic run_reset(string tag, logic [1:0] mode);
    int n = 0;
    bit mode_ok = 1;
    hwr(3'd6, {14'b0, mode});
    hwr(3'd4, 16'h0071);
    hwr(3'd5, 16'h0001);
    while (tgt_rst_o && n < 100) begin
      if (boot_mode_o !== mode) mode_ok = 0;
      n++;
      @(negedge clk_i);
    end
    chk({tag, " pulse length"}, n, RLEN);
    chk({tag, " boot mode held"}, mode_ok, 1);
    chk({tag, " boot mode idle"}, boot_mode_o, 0);
  endtask

  initial begin
    logic [15:0] d;
    logic [7:0]  b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1
    hrd(3'd0, d); chk("R1 status", d, 16'h000C);
    chk("R1 reset out", tgt_rst_o, 0);
    chk("R1 boot mode", boot_mode_o, 0);

    // R2 command handoff
    hwr(3'd1, 16'h0004);
    hwr(3'd5, 16'h0000);
    hrd(3'd0, d); chk("R2 no arm without bit4", d[3], 1);
    hwr(3'd5, 16'h0010);
    hrd(3'd0, d); chk("R2 accept cleared", d[3], 0);
    hrd(3'd5, d); chk("R2 mode pending bit", d, 16'h0010);
    trd(2'd0, b); chk("R2 target readable", b[4], 1);
    trd(2'd1, b); chk("R2 target byte", b, 8'h04);
    twr(2'd2, 8'h20);
    trd(2'd0, b); chk("R2 target ack clears", b[4], 0);
    hrd(3'd0, d); chk("R2 accept restored", d[3], 1);

    // R4 result handoff
    trd(2'd0, b); chk("R4 target may write", b[3], 1);
    twr(2'd1, 8'h02);
    hrd(3'd0, d); chk("R4 result flag", d[4], 1);
    trd(2'd0, b); chk("R4 target write blocked", b[3], 0);
    hrd(3'd1, d); chk("R4 result byte", d, 16'h0002);

    // R3 acknowledge codes
    hwr(3'd4, 16'h0033);
    hrd(3'd0, d); chk("R3 other code keeps flag", d[4], 1);
    hwr(3'd4, 16'h0020);
    hrd(3'd0, d); chk("R3 ack clears flag", d[4], 0);

    // R5 overrun
    twr(2'd1, 8'h11);
    hrd(3'd0, d); chk("R5 no overrun on first", d[5], 0);
    twr(2'd1, 8'h22);
    hrd(3'd0, d); chk("R5 overrun set", d[5], 1);
    hrd(3'd1, d); chk("R5 byte replaced", d, 16'h0022);
    hwr(3'd4, 16'h0020);
    hrd(3'd0, d); chk("R5 sticky after ack", d[5:4], 2'b10);
    hwr(3'd4, 16'h0001);
    hrd(3'd0, d); chk("R5 finalize clears", d[5], 0);

    // R6 host-to-target FIFO with scoreboard
    for (int i = 0; i < 3; i++) drive_word(16'hA000 + 16'(i), 1);
    monitor_drain("R6 short");
    for (int i = 0; i < DEPTH; i++) drive_word(16'h5A00 + 16'(i * 7), 1);
    hrd(3'd0, d); chk("R6 write ready low when full", d[2], 0);
    drive_word(16'hDEAD, 0);
    monitor_drain("R6 full");
    chk("R6 dropped word absent", tgt_word_vld_o, 0);
    hrd(3'd0, d); chk("R6 write ready back", d[2], 1);

    // R7 target-to-host FIFO
    hrd(3'd0, d); chk("R7 empty flags", d[1:0], 2'b00);
    tpush(16'h1234);
    hrd(3'd0, d); chk("R7 word ready", d[1:0], 2'b01);
    for (int i = 1; i < BULK - 1; i++) tpush(16'h2000 + 16'(i));
    hrd(3'd0, d); chk("R7 below bulk", d[1:0], 2'b01);
    tpush(16'h3FFF);
    hrd(3'd0, d); chk("R7 bulk ready", d[1:0], 2'b11);
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      hrd(3'd2, d); chk("R7 read order", d, e);
    end
    hrd(3'd0, d); chk("R7 drained", d[1:0], 2'b00);

    // R8 reset pulses
    run_reset("R8 debug", 2'd1);
    run_reset("R8 console", 2'd2);

    // R9 no trigger without adjacent arm
    hwr(3'd5, 16'h0001);
    @(negedge clk_i); chk("R9 bare mode write", tgt_rst_o, 0);
    hwr(3'd4, 16'h0071);
    hwr(3'd4, 16'h0020);
    hwr(3'd5, 16'h0001);
    @(negedge clk_i); chk("R9 cancelled by control", tgt_rst_o, 0);
    hwr(3'd4, 16'h0071);
    hwr(3'd5, 16'h0002);
    hwr(3'd5, 16'h0001);
    @(negedge clk_i); chk("R9 cancelled by mode", tgt_rst_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule